// File: doc/BRIEF.md
# ISA Bus Strobe Timing Controller

This block runs one external ISA-style bus cycle at a time for an upstream bus bridge. The bridge raises a request that names the direction (read or write), the space (memory or I/O) and whether the target is internal or external. The block then drives the matching active-low strobe. It also controls the direction and enable pins of an external data buffer. When the cycle is done it returns a one-clock acknowledge upstream, together with the captured read data.

The block runs on a clock at twice the bus-clock rate. One `clk` period is therefore half a bus clock, so strobe widths fall in half-bus-clock steps. A small control register holds:
- a 2-bit wait code for memory cycles;
- a separate 2-bit wait code for I/O cycles;
- a buffer-control override;
- two result-cycle enables, one for internal targets and one for external targets.

With a result cycle enabled, a read is handed upstream in a dedicated result cycle right after the strobe ends. Without it, the bridge is held through a hold phase before the acknowledge.

Top module: `isa_strobe_ctl`

## Requirements
- R1: The memory wait code (register bits 2:1) sets the memory strobe width to 3, 5, 7 or 9 `clk` periods (1.5, 2.5, 3.5 or 4.5 bus clocks) for codes 0, 1, 2 and 3.
- R2: The I/O wait code (register bits 4:3) sets the I/O strobe width with the same encoding, independently of the memory code.
- R3: Only one strobe is active at a time, and it is the one that matches the request: `memRdN`, `memWrN`, `ioRdN` or `ioWrN`. During a write strobe, `isaDataOe` is 1 and `isaDataOut` equals the request's write data.
- R4: While the buffer-override bit (register bit 0) is 1, `bufDir` and `bufEnN` are both 0 at all times.
- R5: While the buffer-override bit is 0, `bufEnN` is 0 from the setup clock through the end of the strobe (and through the hold phase of a held read), and 1 otherwise. `bufDir` is 1 only while the buffer is enabled on a write.
- R6: Read data is captured on the edge at which the strobe deasserts and appears on `rdData` while `reqAck` is high. Values on `isaDataIn` after that edge have no effect.
- R7: For a read whose result-cycle enable is 1, `reqAck` and `resultCycle` are both high in the first `clk` after the strobe deasserts, and the buffer is already released.
- R8: For a read whose result-cycle enable is 0, the buffer stays enabled for HOLD_CYC clocks after the strobe. `reqAck` then rises HOLD_CYC+1 clocks after the strobe deasserts, with `resultCycle` low.
- R9: Internal targets use the internal result enable (register bit 6). External targets use the external result enable (register bit 5).
- R10: After reset the register reads 0. Bits above bit 6 always read 0, and bits 6:0 read back as written.
- R11: Wait codes are sampled when a request is accepted, so a register write during a cycle affects only later cycles.
- R12: `reqAck` is a single-clock pulse, one per request. For writes it comes in the first `clk` after the strobe deasserts, with `resultCycle` low.
- R13: The buffer is enabled for one setup clock before the strobe asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | REG_W | Control register write value |
| regRdData | output | REG_W | Control register read value |
| reqValid | input | 1 | Upstream request, held until acknowledged |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqIsIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqInternal | input | 1 | 1 = internal target, 0 = external target |
| reqWrData | input | DATA_W | Write data for the cycle |
| reqAck | output | 1 | One-clock completion pulse |
| resultCycle | output | 1 | High when the acknowledge is a result cycle |
| rdData | output | DATA_W | Captured read data |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ioRdN | output | 1 | I/O read strobe, active low |
| ioWrN | output | 1 | I/O write strobe, active low |
| bufDir | output | 1 | Buffer direction, 1 = toward the bus |
| bufEnN | output | 1 | Buffer enable, active low |
| isaDataOut | output | DATA_W | Data driven onto the bus |
| isaDataOe | output | 1 | Output enable for isaDataOut |
| isaDataIn | input | DATA_W | Data read from the bus |

## Verification
The bench sweeps all four wait codes in both spaces while the other code holds a different value. A design that swapped or shared the fields, or was off by a half step, would produce strobe widths that do not match.

It changes `isaDataIn` right after the strobe deasserts. A design that captured one clock late would return the changed value.

It runs internal and external reads under mixed result enables. Choosing the wrong enable would move the acknowledge by HOLD_CYC clocks or flip `resultCycle`.

It writes new wait codes in the middle of a cycle. A design that did not latch the code at acceptance would stretch or shrink the running strobe.

// File: rtl/isa_strobe_pkg.sv
package isa_strobe_pkg;

  localparam int WAIT_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE,
    ST_RESULT
  } phase_t;

  // control register fields
  typedef struct packed {
    logic              intRes;
    logic              extRes;
    logic [WAIT_W-1:0] ioWait;
    logic [WAIT_W-1:0] memWait;
    logic              bufOff;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // strobes from control to datapath
  typedef struct packed {
    logic bufOn;
    logic strobeOn;
    logic isWrite;
    logic isIo;
    logic captureNow;
    logic loadReq;
    logic ackNow;
    logic resultNow;
  } ctl_t;

endpackage

// File: rtl/isa_strobe_fsm.sv
module isa_strobe_fsm
  import isa_strobe_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rstN,
  input  cfg_t cfg,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic reqIsIo,
  input  logic reqInternal,
  output ctl_t ctl
);

  localparam int MAX_CODE   = (1 << WAIT_W) - 1;
  localparam int MAX_STROBE = 2 * MAX_CODE + 3;
  localparam int MAX_COUNT  = (HOLD_CYC > MAX_STROBE) ? HOLD_CYC : MAX_STROBE;
  localparam int CNT_W      = $clog2(MAX_COUNT + 1);

  phase_t            curState;
  logic [CNT_W-1:0]  cnt;
  logic [WAIT_W-1:0] waitLat;
  logic              curWrite;
  logic              curIo;
  logic              curResEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= ST_IDLE;
      cnt      <= '0;
      waitLat  <= '0;
      curWrite <= 1'b0;
      curIo    <= 1'b0;
      curResEn <= 1'b0;
    end else begin
      unique case (curState)
        ST_IDLE: begin
          if (reqValid) begin
            curState <= ST_SETUP;
            curWrite <= reqWrite;
            curIo    <= reqIsIo;
            curResEn <= reqInternal ? cfg.intRes : cfg.extRes;
            waitLat  <= reqIsIo ? cfg.ioWait : cfg.memWait;
          end
        end
        ST_SETUP: begin
          curState <= ST_STROBE;
          cnt      <= CNT_W'(2 * int'(waitLat) + 2);
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            if (curWrite) begin
              curState <= ST_DONE;
            end else if (curResEn) begin
              curState <= ST_RESULT;
            end else begin
              curState <= ST_HOLD;
              cnt      <= CNT_W'(HOLD_CYC - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) curState <= ST_DONE;
          else           cnt      <= cnt - 1'b1;
        end
        ST_DONE:   curState <= ST_IDLE;
        ST_RESULT: curState <= ST_IDLE;
        default:   curState <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.bufOn      = (curState == ST_SETUP) || (curState == ST_STROBE) ||
                     (curState == ST_HOLD);
    ctl.strobeOn   = (curState == ST_STROBE);
    ctl.isWrite    = curWrite;
    ctl.isIo       = curIo;
    ctl.captureNow = (curState == ST_STROBE) && (cnt == '0) && !curWrite;
    ctl.loadReq    = (curState == ST_IDLE) && reqValid;
    ctl.ackNow     = (curState == ST_DONE) || (curState == ST_RESULT);
    ctl.resultNow  = (curState == ST_RESULT);
  end

  // R13: setup lasts exactly one clock before the strobe
  assert_setup_one_clk_R13: assert property (@(posedge clk) disable iff (!rstN)
    curState == ST_SETUP |=> curState == ST_STROBE);

  // R11: latched wait code cannot move while a strobe is running
  assert_wait_code_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    curState == ST_STROBE |=> $stable(waitLat));

  // R8: the hold phase only follows reads
  assert_hold_reads_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    curState == ST_HOLD |-> !curWrite);

  // R12: a write never ends in a result cycle
  assert_write_no_result_R12: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_STROBE && curWrite) |=> curState != ST_RESULT);

endmodule

// File: rtl/isa_strobe_dp.sv
module isa_strobe_dp
  import isa_strobe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  output cfg_t              cfg,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              reqAck,
  output logic              resultCycle,
  output logic [DATA_W-1:0] rdData,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              bufDir,
  output logic              bufEnN,
  output logic [DATA_W-1:0] isaDataOut,
  output logic              isaDataOe,
  input  logic [DATA_W-1:0] isaDataIn
);

  localparam int PAD_W = REG_W - CFG_W;

  cfg_t              cfgQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '0;
      wrDataQ <= '0;
      rdDataQ <= '0;
    end else begin
      if (regWrEn)        cfgQ    <= cfg_t'(regWrData[CFG_W-1:0]);
      if (ctl.loadReq)    wrDataQ <= reqWrData;
      if (ctl.captureNow) rdDataQ <= isaDataIn;
    end
  end

  assign cfg       = cfgQ;
  assign regRdData = {{PAD_W{1'b0}}, cfgQ};

  assign memRdN = !(ctl.strobeOn && !ctl.isWrite && !ctl.isIo);
  assign memWrN = !(ctl.strobeOn &&  ctl.isWrite && !ctl.isIo);
  assign ioRdN  = !(ctl.strobeOn && !ctl.isWrite &&  ctl.isIo);
  assign ioWrN  = !(ctl.strobeOn &&  ctl.isWrite &&  ctl.isIo);

  assign bufEnN = cfgQ.bufOff ? 1'b0 : !ctl.bufOn;
  assign bufDir = cfgQ.bufOff ? 1'b0 : (ctl.bufOn && ctl.isWrite);

  assign isaDataOe   = ctl.bufOn && ctl.isWrite;
  assign isaDataOut  = wrDataQ;
  assign reqAck      = ctl.ackNow;
  assign resultCycle = ctl.resultNow;
  assign rdData      = rdDataQ;

  // R3: at most one strobe pin low
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~memRdN, ~memWrN, ~ioRdN, ~ioWrN}));

  // R4: override forces both buffer pins low
  assert_buf_forced_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.bufOff |-> (!bufDir && !bufEnN));

  // R12: acknowledge lasts a single clock
  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R6: read data only moves on a capture edge
  assert_rd_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.captureNow |=> $stable(rdData));

endmodule

// File: rtl/isa_strobe_ctl.sv
module isa_strobe_ctl
  import isa_strobe_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int REG_W    = 16,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIsIo,
  input  logic              reqInternal,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              reqAck,
  output logic              resultCycle,
  output logic [DATA_W-1:0] rdData,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              bufDir,
  output logic              bufEnN,
  output logic [DATA_W-1:0] isaDataOut,
  output logic              isaDataOe,
  input  logic [DATA_W-1:0] isaDataIn
);

  ctl_t ctlBus;
  cfg_t cfgBus;

  isa_strobe_fsm #(.HOLD_CYC(HOLD_CYC)) uFsm (
    .clk        (clk),
    .rstN       (rstN),
    .cfg        (cfgBus),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqIsIo    (reqIsIo),
    .reqInternal(reqInternal),
    .ctl        (ctlBus)
  );

  isa_strobe_dp #(.DATA_W(DATA_W), .REG_W(REG_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctlBus),
    .cfg        (cfgBus),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .reqWrData  (reqWrData),
    .reqAck     (reqAck),
    .resultCycle(resultCycle),
    .rdData     (rdData),
    .memRdN     (memRdN),
    .memWrN     (memWrN),
    .ioRdN      (ioRdN),
    .ioWrN      (ioWrN),
    .bufDir     (bufDir),
    .bufEnN     (bufEnN),
    .isaDataOut (isaDataOut),
    .isaDataOe  (isaDataOe),
    .isaDataIn  (isaDataIn)
  );

endmodule

// File: tb/isa_strobe_ctl_test.sv
`timescale 1ns/1ps
module isa_strobe_ctl_test;

  localparam int DW   = 16;
  localparam int RW   = 16;
  localparam int HOLD = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [RW-1:0] regWrData = '0;
  logic [RW-1:0] regRdData;
  logic          reqValid = 1'b0, reqWrite = 1'b0, reqIsIo = 1'b0, reqInternal = 1'b0;
  logic [DW-1:0] reqWrData = '0;
  logic          reqAck, resultCycle;
  logic [DW-1:0] rdData;
  logic          memRdN, memWrN, ioRdN, ioWrN, bufDir, bufEnN;
  logic [DW-1:0] isaDataOut;
  logic          isaDataOe;
  logic [DW-1:0] isaDataIn = '0;

  always #2.5 clk = ~clk;

  isa_strobe_ctl #(.DATA_W(DW), .REG_W(RW), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIsIo(reqIsIo), .reqInternal(reqInternal), .reqWrData(reqWrData),
    .reqAck(reqAck), .resultCycle(resultCycle), .rdData(rdData),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .bufDir(bufDir), .bufEnN(bufEnN), .isaDataOut(isaDataOut),
    .isaDataOe(isaDataOe), .isaDataIn(isaDataIn)
  );

  typedef struct {
    logic [3:0]    sel;     // {ioWr, ioRd, memWr, memRd}
    int            width;
    int            delay;
    bit            isRead;
    bit            result;
    bit            held;
    logic [DW-1:0] rdPat;
    logic [DW-1:0] wdata;
  } exp_t;

  exp_t          expQ[$];
  int            compared = 0;
  int            mismatched = 0;
  logic [RW-1:0] shadow = '0;
  bit            done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [RW-1:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
    shadow = val;
  endtask

  // driver: predicts the cycle, pushes it, runs the handshake
  task automatic busCycle(input bit wr, input bit io, input bit intl,
                          input logic [DW-1:0] wd, input logic [DW-1:0] pat);
    exp_t e;
    int   code;
    bit   resEn;
    code   = io ? int'(shadow[4:3]) : int'(shadow[2:1]);
    resEn  = intl ? shadow[6] : shadow[5];
    e.sel    = 4'b0001 << {io, wr};
    e.width  = 2 * code + 3;
    e.isRead = !wr;
    e.result = !wr && resEn;
    e.held   = !wr && !resEn;
    e.delay  = e.held ? HOLD + 1 : 1;
    e.rdPat  = pat;
    e.wdata  = wd;
    expQ.push_back(e);
    @(negedge clk);
    isaDataIn = pat;
    reqValid = 1'b1; reqWrite = wr; reqIsIo = io; reqInternal = intl; reqWrData = wd;
    do @(negedge clk); while (!reqAck);
    reqValid = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  bit         inStrobe = 1'b0, waiting = 1'b0;
  int         wCnt = 0, aCnt = 0;
  logic [3:0] curSel = '0;
  logic       prevBufEnN = 1'b1;

  always @(negedge clk) begin
    logic [3:0] stb;
    exp_t       h;
    stb = {~ioWrN, ~ioRdN, ~memWrN, ~memRdN};
    if (rstN && !done) begin
      if (stb != 4'b0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12 strobe without request", stb, 0);
        end else begin
          h = expQ[0];
          if (!inStrobe) begin
            inStrobe = 1'b1; wCnt = 0; curSel = stb;
            if (!shadow[0]) check(prevBufEnN == 1'b0, "R13 buffer on before strobe", prevBufEnN, 0);
          end
          wCnt++;
          check(stb == h.sel, "R3 strobe select", stb, h.sel);
          if (shadow[0]) begin
            check(!bufDir && !bufEnN, "R4 buffer pins forced low", {bufDir, bufEnN}, 0);
          end else begin
            check(!bufEnN && (bufDir == !h.isRead), "R5 buffer pins in strobe",
                  {bufDir, bufEnN}, {!h.isRead, 1'b0});
          end
          if (!h.isRead)
            check(isaDataOe && isaDataOut == h.wdata, "R3 write data on bus",
                  {isaDataOe, isaDataOut}, {1'b1, h.wdata});
        end
      end else if (inStrobe) begin
        inStrobe = 1'b0; waiting = 1'b1; aCnt = 0;
        isaDataIn = ~isaDataIn;  // later bus values must not be captured (R6)
      end
      if (waiting && stb == 4'b0 && expQ.size() > 0) begin
        h = expQ[0];
        aCnt++;
        if (!reqAck && h.held)
          check(!bufEnN, "R8 buffer held through hold", bufEnN, 0);
        if (reqAck) begin
          void'(expQ.pop_front());
          waiting = 1'b0;
          check(curSel == h.sel, "R3 strobe kind", curSel, h.sel);
          check(wCnt == h.width, h.sel[1] | h.sel[0] ? "R1 memory strobe width" : "R2 io strobe width",
                wCnt, h.width);
          check(aCnt == h.delay, h.isRead ? (h.held ? "R8 held ack delay" : "R7 result ack delay")
                : "R12 write ack delay", aCnt, h.delay);
          check(resultCycle == h.result, "R9 result cycle flag", resultCycle, h.result);
          if (h.isRead) check(rdData == h.rdPat, "R6 captured read data", rdData, h.rdPat);
          check(bufEnN == !shadow[0], "R5 buffer released at ack", bufEnN, !shadow[0]);
        end else if (aCnt > HOLD + 2) begin
          check(1'b0, "R12 ack missing", aCnt, h.delay);
          void'(expQ.pop_front());
          waiting = 1'b0;
        end
      end else if (reqAck && !waiting) begin
        check(1'b0, "R12 unexpected ack", 1, 0);
      end
    end
    prevBufEnN = bufEnN;
  end

  task automatic finishRun();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(regRdData == '0, "R10 reset register", regRdData, 0);
    check({memRdN, memWrN, ioRdN, ioWrN} == 4'hF, "R3 strobes idle after reset",
          {memRdN, memWrN, ioRdN, ioWrN}, 4'hF);
    check(bufEnN && !reqAck, "R5 buffer off after reset", {bufEnN, reqAck}, 2'b10);

    writeReg(16'hFFFF);
    check(regRdData == 16'h007F, "R10 upper bits read zero", regRdData, 16'h007F);
    writeReg(16'h0055);
    check(regRdData == 16'h0055, "R10 readback", regRdData, 16'h0055);

    // R1/R2: sweep each code while the other field holds the mirror code
    for (int c = 0; c < 4; c++) begin
      writeReg(RW'(16'h0060 | (c << 1) | ((3 - c) << 3)));
      busCycle(1'b0, 1'b0, 1'b0, 16'h0, 16'hA500 + 16'(c));   // mem read
      busCycle(1'b1, 1'b0, 1'b1, 16'h1200 + 16'(c), 16'h0);   // mem write
      busCycle(1'b0, 1'b1, 1'b1, 16'h0, 16'h5A00 + 16'(c));   // io read
      busCycle(1'b1, 1'b1, 1'b0, 16'h3400 + 16'(c), 16'h0);   // io write
    end

    // R9/R7/R8: only the internal enable set
    writeReg(16'h0042);
    busCycle(1'b0, 1'b0, 1'b0, 16'h0, 16'hBEEF);  // external: held
    busCycle(1'b0, 1'b0, 1'b1, 16'h0, 16'hCAFE);  // internal: result
    writeReg(16'h0022);                          // only external enable set
    busCycle(1'b0, 1'b1, 1'b0, 16'h0, 16'h1357);
    busCycle(1'b0, 1'b1, 1'b1, 16'h0, 16'h2468);

    // R4: buffer override
    writeReg(16'h0067);
    busCycle(1'b1, 1'b0, 1'b0, 16'h7777, 16'h0);
    busCycle(1'b0, 1'b1, 1'b0, 16'h0, 16'h8888);
    check(!bufDir && !bufEnN, "R4 idle pins forced low", {bufDir, bufEnN}, 0);

    // R11: register write mid-cycle does not alter the running strobe
    writeReg(16'h0060);
    fork
      busCycle(1'b0, 1'b0, 1'b0, 16'h0, 16'h0F0F);
      begin
        repeat (3) @(negedge clk);
        regWrEn = 1'b1; regWrData = 16'h007E;
        @(negedge clk);
        regWrEn = 1'b0;
      end
    join
    shadow = 16'h007E;
    busCycle(1'b1, 1'b0, 1'b0, 16'h4242, 16'h0);   // R11 new code now in force

    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R12 every request acknowledged", expQ.size(), 0);
    finishRun();
  end

endmodule